// File: doc/BRIEF.md
# Byte-Wide Nonvolatile Memory Page-Write Controller

This block is a clocked, synthesizable model of the control logic of a 2048-by-8 byte-wide nonvolatile memory. It samples three active-low strobes, an 11-bit address and an 8-bit input data bus. The strobes are a chip select, an output enable and a write enable, and the block treats all three as asynchronous. It drives an 8-bit read bus and a separate output-enable for a tri-state pad. Reads return the stored byte whenever chip select and output enable are low and write enable is high. At all other times the read bus is released.

A write is a sequence of byte loads. Each byte goes into a 16-byte page buffer. The upper seven address bits name the page and the low four bits name the byte within it. A load that starts within a fixed window after the previous load extends the same page write, so a page write has no overall time limit. Once the window runs out with no new load, a timed programming cycle starts. At its end the loaded bytes are copied into the storage array, and bytes that were not loaded keep their old contents.

While programming runs, the block ignores new loads. A read of the last byte written returns that byte with its top bit inverted, so software can poll for completion. Strobe overlaps that are too short are rejected as glitches. A load aimed at a different page from the one being collected is dropped, and a sticky error flag is raised.

Top module: `nvpage_ctrl`

## Requirements
- R1: With chip_sel_n=0, out_en_n=0 and wr_en_n=1 sampled, rdata_oe is 1 and rdata equals the stored byte at mem_addr (when no programming cycle is running, or the address is not the last one written).
- R2: rdata_oe is 0 whenever chip_sel_n or out_en_n is sampled high.
- R3: A byte load happens while chip_sel_n=0, wr_en_n=0 and out_en_n=1 all hold. The address is taken at the start of that overlap, that is, at the later of the two falling strobes. The data is the last value present before the overlap ends, that is, at the earlier of the two rising strobes. The load works whether chip select or write enable is the strobe that falls last.
- R4: mem_addr[10:4] selects the page and mem_addr[3:0] the byte within it. From 1 to 16 loads to one page are committed by a single programming cycle, and bytes of that page that were not loaded keep their previous value.
- R5: Programming starts only after LOAD_WIN cycles pass since the start of the latest accepted load with no new accepted load. Each load that arrives in time restarts the window, with no limit on the total length of the page write.
- R6: prog_busy stays high for exactly PROG_CYC cycles, after which reads return the newly written data.
- R7: While prog_busy is 1, a read of the last written address returns that byte with bit 7 inverted and bits 6..0 true. After completion, all 8 bits are true.
- R8: A write overlap that lasts GLITCH_CYC sampled cycles or less is ignored. An overlap one cycle longer is accepted.
- R9: Byte loads started while prog_busy is 1 are ignored: they change no stored byte and start no further programming cycle.
- R10: A load whose page bits differ from the first load of the page being collected is dropped, and page_err is set. page_err stays set until the first load of the next page write.
- R11: After reset, prog_busy=0, page_err=0 and rdata_oe=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| chip_sel_n | input | 1 | Active-low chip select, asynchronous |
| out_en_n | input | 1 | Active-low output enable, asynchronous |
| wr_en_n | input | 1 | Active-low write enable, asynchronous |
| mem_addr | input | 11 | Byte address: page in [10:4], byte in [3:0] |
| wdata | input | 8 | Write data from the pad |
| rdata | output | 8 | Read data toward the pad |
| rdata_oe | output | 1 | Pad drive enable for rdata |
| prog_busy | output | 1 | Programming cycle in progress |
| page_err | output | 1 | Sticky flag: a load to a foreign page was dropped |

## Verification
The bench builds the block with a load window of 40 cycles, a programming time of 60 cycles and a glitch limit of 2 cycles. These short values let a full 16-byte page write, a deliberately delayed load inside the window, and the window expiry all fit in a few hundred cycles. They also allow the exact programming length to be counted cycle for cycle. The short programming time still leaves room for a polling read and an ignored load to land inside one busy period. The 2-cycle glitch limit lets the bench probe both sides of the rejection threshold with pulses of 2 and 3 cycles.

// File: rtl/nvpage_pkg.sv
// Shared types and constants of the nonvolatile page-write controller.
package nvpage_pkg;
    // Number of flops used to bring the asynchronous strobes into clk.
    localparam int unsigned NV_SYNC = 2;

    // Controller phases.
    typedef enum logic [1:0] {
        NV_IDLE    = 2'd0,   // no page write open
        NV_COLLECT = 2'd1,   // loads being gathered, window running
        NV_PROG    = 2'd2    // timed programming cycle
    } nv_state_e;
endpackage

// File: rtl/nvpage_strobe.sv
// Strobe front end.
// Brings chip select, output enable and write enable into the clock domain,
// and delays address and data by the same number of stages so that they
// stay aligned with the strobes. A write overlap must be seen for more than
// GLITCH_CYC cycles before it counts as a load. ld_start marks the first
// valid cycle (address taken there), and ld_end marks the cycle after the
// overlap ends. ld_data holds the last data seen inside the overlap.
// Assumes: address stable for GLITCH_CYC+1 cycles after the overlap begins.
module nvpage_strobe
    import nvpage_pkg::*;
#(
    parameter int unsigned ADDR_W     = 11,
    parameter int unsigned DATA_W     = 8,
    parameter int unsigned GLITCH_CYC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_n_i,
    input  logic              oe_n_i,
    input  logic              we_n_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              rd_en_o,
    output logic              ld_start_o,
    output logic              ld_end_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] ld_data_o
);
    localparam int unsigned GW = $clog2(GLITCH_CYC + 1);

    logic [NV_SYNC-1:0] sel_sh, oe_sh, we_sh;
    logic [ADDR_W-1:0]  a_pipe [NV_SYNC];
    logic [DATA_W-1:0]  d_pipe [NV_SYNC];
    logic               sel_s, oe_s, we_s, wr_raw, ld_act, act_q;
    logic [GW-1:0]      gcnt;
    logic [DATA_W-1:0]  dat_q;

    // Synchronise strobes (reset to inactive) and align address and data with them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_sh <= '1;
            oe_sh  <= '1;
            we_sh  <= '1;
            for (int i = 0; i < NV_SYNC; i++) begin
                a_pipe[i] <= '0;
                d_pipe[i] <= '0;
            end
        end else begin
            sel_sh    <= {sel_sh[NV_SYNC-2:0], sel_n_i};
            oe_sh     <= {oe_sh[NV_SYNC-2:0], oe_n_i};
            we_sh     <= {we_sh[NV_SYNC-2:0], we_n_i};
            a_pipe[0] <= addr_i;
            d_pipe[0] <= data_i;
            for (int i = 1; i < NV_SYNC; i++) begin
                a_pipe[i] <= a_pipe[i-1];
                d_pipe[i] <= d_pipe[i-1];
            end
        end
    end

    assign sel_s  = sel_sh[NV_SYNC-1];
    assign oe_s   = oe_sh[NV_SYNC-1];
    assign we_s   = we_sh[NV_SYNC-1];
    assign wr_raw = ~sel_s & ~we_s & oe_s;

    // Count how long the write overlap has lasted, saturating at the glitch limit.
    always_ff @(posedge clk) begin
        if (!rst_n)                        gcnt <= '0;
        else if (!wr_raw)                  gcnt <= '0;
        else if (gcnt != GW'(GLITCH_CYC))  gcnt <= gcnt + 1'b1;
    end

    assign ld_act = wr_raw & (gcnt == GW'(GLITCH_CYC));

    // Remember the previous load-active level and the latest data inside the overlap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q <= 1'b0;
            dat_q <= '0;
        end else begin
            act_q <= ld_act;
            if (ld_act) dat_q <= d_pipe[NV_SYNC-1];
        end
    end

    assign ld_start_o = ld_act & ~act_q;
    assign ld_end_o   = act_q & ~ld_act;
    assign ld_data_o  = dat_q;
    assign addr_o     = a_pipe[NV_SYNC-1];
    assign rd_en_o    = ~sel_s & ~oe_s & we_s;
endmodule

// File: rtl/nvpage_loadbuf.sv
// Page load buffer.
// One byte register and one valid bit per byte of the page. A write stores
// a byte at its offset and marks it valid. clr drops all valid bits after a
// commit. Assumes wr and clr never coincide (the sequencer guarantees it).
module nvpage_loadbuf #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned OFF_W  = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_i,
    input  logic [OFF_W-1:0]              off_i,
    input  logic [DATA_W-1:0]             data_i,
    input  logic                          clr_i,
    output logic [(2**OFF_W)*DATA_W-1:0]  bytes_o,
    output logic [(2**OFF_W)-1:0]         mask_o
);
    localparam int unsigned PG_BYTES = 2 ** OFF_W;

    for (genvar g = 0; g < PG_BYTES; g++) begin : g_lane
        logic [DATA_W-1:0] b_q;
        logic              v_q;

        // Hold one page byte and its loaded flag.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                b_q <= '0;
                v_q <= 1'b0;
            end else if (clr_i) begin
                v_q <= 1'b0;
            end else if (wr_i && off_i == OFF_W'(g)) begin
                b_q <= data_i;
                v_q <= 1'b1;
            end
        end

        assign bytes_o[g*DATA_W +: DATA_W] = b_q;
        assign mask_o[g]                   = v_q;
    end
endmodule

// File: rtl/nvpage_seq.sv
// Page-write sequencer.
// Opens a page write on the first load, accepts further loads to the same
// page while the load window runs, drops loads to other pages (sticky
// error), then runs a programming timer and issues a one-cycle commit at
// its end. Loads that start during programming are ignored. It also keeps
// the last written address and byte for status polling.
// Assumes: LOAD_WIN >= 1, PROG_CYC >= 1.
module nvpage_seq
    import nvpage_pkg::*;
#(
    parameter int unsigned ADDR_W   = 11,
    parameter int unsigned DATA_W   = 8,
    parameter int unsigned OFF_W    = 4,
    parameter int unsigned LOAD_WIN = 2000,
    parameter int unsigned PROG_CYC = 500000
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ld_start_i,
    input  logic                    ld_end_i,
    input  logic [ADDR_W-1:0]       addr_i,
    input  logic [DATA_W-1:0]       ld_data_i,
    output logic                    buf_wr_o,
    output logic [OFF_W-1:0]        buf_off_o,
    output logic                    commit_o,
    output logic [ADDR_W-OFF_W-1:0] page_o,
    output logic                    busy_o,
    output logic                    page_err_o,
    output logic [ADDR_W-1:0]       last_addr_o,
    output logic [DATA_W-1:0]       last_data_o,
    output nv_state_e               state_o
);
    localparam int unsigned PG_W = ADDR_W - OFF_W;
    localparam int unsigned WW   = $clog2(LOAD_WIN + 1);
    localparam int unsigned PW   = $clog2(PROG_CYC + 1);

    nv_state_e         st;
    logic [PG_W-1:0]   page_q;
    logic [OFF_W-1:0]  off_q;
    logic              acc_q, err_q, same_page, take, win_done;
    logic [WW-1:0]     win_cnt;
    logic [PW-1:0]     prog_cnt;
    logic [ADDR_W-1:0] last_a_q;
    logic [DATA_W-1:0] last_d_q;

    assign same_page = (addr_i[ADDR_W-1:OFF_W] == page_q);
    assign take      = ld_start_i & (st != NV_PROG) & ((st == NV_IDLE) | same_page);
    assign buf_wr_o  = ld_end_i & acc_q;
    assign win_done  = (st == NV_COLLECT) & (win_cnt == '0) & ~acc_q & ~take;
    assign commit_o  = (st == NV_PROG) & (prog_cnt == PW'(1));

    // Phase transitions and programming timer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= NV_IDLE;
            prog_cnt <= '0;
        end else begin
            unique case (st)
                NV_IDLE:    if (take) st <= NV_COLLECT;
                NV_COLLECT: if (win_done) begin
                                st       <= NV_PROG;
                                prog_cnt <= PW'(PROG_CYC);
                            end
                NV_PROG:    if (commit_o) st <= NV_IDLE;
                            else          prog_cnt <= prog_cnt - 1'b1;
                default:    st <= NV_IDLE;
            endcase
        end
    end

    // Load window: restarted by every accepted load, counts down otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)                win_cnt <= '0;
        else if (take)             win_cnt <= WW'(LOAD_WIN);
        else if (win_cnt != '0)    win_cnt <= win_cnt - 1'b1;
    end

    // Capture page and offset of an accepted load and track it until its data lands.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            page_q <= '0;
            off_q  <= '0;
            acc_q  <= 1'b0;
        end else if (take) begin
            page_q <= addr_i[ADDR_W-1:OFF_W];
            off_q  <= addr_i[OFF_W-1:0];
            acc_q  <= 1'b1;
        end else if (buf_wr_o) begin
            acc_q  <= 1'b0;
        end
    end

    // Sticky foreign-page flag, cleared when a new page write opens.
    always_ff @(posedge clk) begin
        if (!rst_n)                                           err_q <= 1'b0;
        else if (take && st == NV_IDLE)                       err_q <= 1'b0;
        else if (ld_start_i && st == NV_COLLECT && !same_page) err_q <= 1'b1;
    end

    // Last written address and byte, used for status polling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_a_q <= '0;
            last_d_q <= '0;
        end else if (buf_wr_o) begin
            last_a_q <= {page_q, off_q};
            last_d_q <= ld_data_i;
        end
    end

    assign buf_off_o   = off_q;
    assign page_o      = page_q;
    assign busy_o      = (st == NV_PROG);
    assign page_err_o  = err_q;
    assign last_addr_o = last_a_q;
    assign last_data_o = last_d_q;
    assign state_o     = st;
endmodule

// File: rtl/nvpage_array.sv
// Storage array.
// 2**ADDR_W bytes. On commit, every valid byte of the page buffer is written
// to its place in the selected page in one cycle. The read port is
// combinational. Assumes: contents are nonvolatile, so they are not reset.
module nvpage_array #(
    parameter int unsigned ADDR_W = 11,
    parameter int unsigned DATA_W = 8,
    parameter int unsigned OFF_W  = 4
) (
    input  logic                          clk,
    input  logic                          commit_i,
    input  logic [ADDR_W-OFF_W-1:0]       page_i,
    input  logic [(2**OFF_W)*DATA_W-1:0]  bytes_i,
    input  logic [(2**OFF_W)-1:0]         mask_i,
    input  logic [ADDR_W-1:0]             raddr_i,
    output logic [DATA_W-1:0]             rdata_o
);
    localparam int unsigned DEPTH    = 2 ** ADDR_W;
    localparam int unsigned PG_BYTES = 2 ** OFF_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Commit the loaded bytes of one page.
    always_ff @(posedge clk) begin
        if (commit_i) begin
            for (int i = 0; i < PG_BYTES; i++) begin
                if (mask_i[i]) mem[{page_i, OFF_W'(i)}] <= bytes_i[i*DATA_W +: DATA_W];
            end
        end
    end

    assign rdata_o = mem[raddr_i];
endmodule

// File: rtl/nvpage_ctrl.sv
// Top of the byte-wide nonvolatile memory page-write controller.
// Connects the strobe front end, the sequencer, the page buffer and the
// storage array. During programming, a read of the last written address
// returns that byte with its top bit inverted.
// Assumes: strobes are asynchronous and held for several clk cycles.
module nvpage_ctrl
    import nvpage_pkg::*;
#(
    parameter int unsigned ADDR_W     = 11,
    parameter int unsigned DATA_W     = 8,
    parameter int unsigned OFF_W      = 4,
    parameter int unsigned LOAD_WIN   = 2000,
    parameter int unsigned PROG_CYC   = 500000,
    parameter int unsigned GLITCH_CYC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chip_sel_n,
    input  logic              out_en_n,
    input  logic              wr_en_n,
    input  logic [ADDR_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              rdata_oe,
    output logic              prog_busy,
    output logic              page_err
);
    localparam int unsigned PG_W     = ADDR_W - OFF_W;
    localparam int unsigned PG_BYTES = 2 ** OFF_W;

    logic                   rd_en, ld_start, ld_end, buf_wr, commit;
    logic [ADDR_W-1:0]      s_addr, last_addr;
    logic [DATA_W-1:0]      ld_data, last_data, arr_rdata;
    logic [OFF_W-1:0]       buf_off;
    logic [PG_W-1:0]        page;
    logic [PG_BYTES*DATA_W-1:0] buf_bytes;
    logic [PG_BYTES-1:0]    buf_mask;
    nv_state_e              st;

    nvpage_strobe #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .GLITCH_CYC(GLITCH_CYC)) u_strobe (
        .clk(clk), .rst_n(rst_n),
        .sel_n_i(chip_sel_n), .oe_n_i(out_en_n), .we_n_i(wr_en_n),
        .addr_i(mem_addr), .data_i(wdata),
        .rd_en_o(rd_en), .ld_start_o(ld_start), .ld_end_o(ld_end),
        .addr_o(s_addr), .ld_data_o(ld_data)
    );

    nvpage_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFF_W(OFF_W),
                 .LOAD_WIN(LOAD_WIN), .PROG_CYC(PROG_CYC)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .ld_start_i(ld_start), .ld_end_i(ld_end),
        .addr_i(s_addr), .ld_data_i(ld_data),
        .buf_wr_o(buf_wr), .buf_off_o(buf_off), .commit_o(commit), .page_o(page),
        .busy_o(prog_busy), .page_err_o(page_err),
        .last_addr_o(last_addr), .last_data_o(last_data), .state_o(st)
    );

    nvpage_loadbuf #(.DATA_W(DATA_W), .OFF_W(OFF_W)) u_buf (
        .clk(clk), .rst_n(rst_n),
        .wr_i(buf_wr), .off_i(buf_off), .data_i(ld_data), .clr_i(commit),
        .bytes_o(buf_bytes), .mask_o(buf_mask)
    );

    nvpage_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFF_W(OFF_W)) u_arr (
        .clk(clk), .commit_i(commit), .page_i(page),
        .bytes_i(buf_bytes), .mask_i(buf_mask),
        .raddr_i(s_addr), .rdata_o(arr_rdata)
    );

    // Read mux: status byte for the last written address while busy, array otherwise.
    always_comb begin
        if (prog_busy && s_addr == last_addr)
            rdata = {~last_data[DATA_W-1], last_data[DATA_W-2:0]};
        else
            rdata = arr_rdata;
    end

    assign rdata_oe = rd_en;
endmodule

// File: rtl/nvpage_ctrl_chk.sv
// Assertion checker for nvpage_ctrl, attached by bind.
// Observes the pins, the sequencer phase and the page buffer.
module nvpage_ctrl_chk
    import nvpage_pkg::*;
#(
    parameter int unsigned PG_BYTES = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic                chip_sel_n,
    input logic                out_en_n,
    input logic                wr_en_n,
    input logic                rdata_oe,
    input logic                prog_busy,
    input logic                page_err,
    input nv_state_e           st,
    input logic                buf_wr,
    input logic [PG_BYTES-1:0] buf_mask
);
    // R1 / R2: the pad is driven only after a read-mode strobe combination was sampled.
    p_drive_only_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_oe |-> (!$past(chip_sel_n, 2) && !$past(out_en_n, 2) && $past(wr_en_n, 2)));

    // R9: no byte reaches the page buffer while programming runs.
    p_no_load_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        prog_busy |-> !buf_wr);

    // R10: the foreign-page flag is only raised while a page is being collected.
    p_err_in_collect_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(page_err) |-> $past(st) == NV_COLLECT);

    // R5: programming never starts with an empty page buffer.
    p_prog_nonempty_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(prog_busy) |-> buf_mask != '0);

    // R4: the buffer is emptied when programming completes.
    p_buf_cleared_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(prog_busy) |-> buf_mask == '0);
endmodule

bind nvpage_ctrl nvpage_ctrl_chk #(.PG_BYTES(2 ** OFF_W)) chk_i (
    .clk(clk), .rst_n(rst_n),
    .chip_sel_n(chip_sel_n), .out_en_n(out_en_n), .wr_en_n(wr_en_n),
    .rdata_oe(rdata_oe), .prog_busy(prog_busy), .page_err(page_err),
    .st(st), .buf_wr(buf_wr), .buf_mask(buf_mask)
);

// File: tb/nvpage_ctrl_tb_top.sv
// Self-checking bench for nvpage_ctrl: a vector table walk, then directed tests.
module nvpage_ctrl_tb_top;
    localparam int WIN  = 40;
    localparam int PROG = 60;
    localparam int GL   = 2;

    logic        clk = 1'b0;
    logic        rst_n, chip_sel_n, out_en_n, wr_en_n;
    logic [10:0] mem_addr;
    logic [7:0]  wdata, rdata;
    logic        rdata_oe, prog_busy, page_err;
    int          total = 0, bad = 0, cyc = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    nvpage_ctrl #(.LOAD_WIN(WIN), .PROG_CYC(PROG), .GLITCH_CYC(GL)) dut_i (
        .clk(clk), .rst_n(rst_n), .chip_sel_n(chip_sel_n), .out_en_n(out_en_n),
        .wr_en_n(wr_en_n), .mem_addr(mem_addr), .wdata(wdata), .rdata(rdata),
        .rdata_oe(rdata_oe), .prog_busy(prog_busy), .page_err(page_err)
    );

    // Vector table: {is_write, address, data/expected}.
    localparam logic [19:0] VEC [12] = '{
        {1'b1, 11'h2A3, 8'h5C}, {1'b1, 11'h2A7, 8'h81}, {1'b1, 11'h2AF, 8'h00},
        {1'b0, 11'h2A3, 8'h5C}, {1'b0, 11'h2A7, 8'h81}, {1'b0, 11'h2AF, 8'h00},
        {1'b1, 11'h7F0, 8'hFF}, {1'b1, 11'h7FF, 8'h7E},
        {1'b0, 11'h7F0, 8'hFF}, {1'b0, 11'h7FF, 8'h7E},
        {1'b1, 11'h000, 8'hA5}, {1'b0, 11'h000, 8'hA5}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Byte load; we_last=1 lets write enable fall last, otherwise chip select does.
    task automatic wr_byte(input logic [10:0] a, input logic [7:0] d, input bit we_last);
        out_en_n = 1'b1;
        mem_addr = a ^ 11'h7FF;
        wdata    = ~d;
        if (we_last) chip_sel_n = 1'b0; else wr_en_n = 1'b0;
        tick(1);
        mem_addr = a;
        if (we_last) wr_en_n = 1'b0; else chip_sel_n = 1'b0;
        tick(2);
        wdata = d;
        tick(3);
        if (we_last) wr_en_n = 1'b1; else chip_sel_n = 1'b1;
        wdata = ~d;
        tick(1);
        chip_sel_n = 1'b1;
        wr_en_n    = 1'b1;
        tick(1);
    endtask

    // Both write strobes low together for exactly n cycles.
    task automatic pulse(input logic [10:0] a, input logic [7:0] d, input int n);
        out_en_n = 1'b1; mem_addr = a; wdata = d;
        chip_sel_n = 1'b0; wr_en_n = 1'b0;
        tick(n);
        chip_sel_n = 1'b1; wr_en_n = 1'b1;
        tick(1);
    endtask

    task automatic rd(input logic [10:0] a, output logic [7:0] v, output logic oe);
        chip_sel_n = 1'b0; out_en_n = 1'b0; wr_en_n = 1'b1; mem_addr = a;
        tick(4);
        v  = rdata;
        oe = rdata_oe;
        chip_sel_n = 1'b1; out_en_n = 1'b1;
        tick(1);
    endtask

    task automatic wait_busy();
        for (int w = 0; w < 2000 && !prog_busy; w++) tick(1);
    endtask

    task automatic wait_prog(output int len);
        wait_busy();
        len = 0;
        while (prog_busy && len < 3000) begin
            tick(1);
            len++;
        end
    endtask

    // Watchdog: an overrun counts as a failed check.
    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000 && !done) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=finish", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        logic       oe;
        int         len;
        bit         pending;

        rst_n = 1'b0; chip_sel_n = 1'b1; out_en_n = 1'b1; wr_en_n = 1'b1;
        mem_addr = '0; wdata = '0;
        tick(5);
        chk("R11 busy after reset", prog_busy, 0);
        chk("R11 page_err after reset", page_err, 0);
        chk("R11 rdata_oe after reset", rdata_oe, 0);
        rst_n = 1'b1;
        tick(2);

        // Table walk: R1, R3, R6.
        pending = 1'b0;
        for (int i = 0; i < 12; i++) begin
            if (VEC[i][19]) begin
                wr_byte(VEC[i][18:8], VEC[i][7:0], i[0]);
                pending = 1'b1;
            end else begin
                if (pending) begin
                    wait_prog(len);
                    chk("R6 programming length", len, PROG);
                    pending = 1'b0;
                end
                rd(VEC[i][18:8], v, oe);
                chk("R1 R3 table read data", v, VEC[i][7:0]);
                chk("R1 table read drive", oe, 1);
            end
        end

        // R2: bus released when either select or output enable is high.
        chip_sel_n = 1'b0; out_en_n = 1'b1; tick(4);
        chk("R2 released, out_en high", rdata_oe, 0);
        chip_sel_n = 1'b1; out_en_n = 1'b0; tick(4);
        chk("R2 released, chip_sel high", rdata_oe, 0);
        out_en_n = 1'b1; tick(1);

        // R4 / R5: full 16-byte page with a late (but in-window) load.
        for (int i = 0; i < 16; i++) begin
            wr_byte({7'h05, 4'(i)}, 8'h30 + 8'(i), i[0]);
            if (i == 7) begin
                tick(25);
                chk("R5 window restarted by loads", prog_busy, 0);
            end
        end
        tick(15);
        chk("R5 no programming inside window", prog_busy, 0);
        wait_prog(len);
        chk("R6 full page length", len, PROG);
        wr_byte(11'h053, 8'hC3, 1'b1);
        wr_byte(11'h059, 8'h19, 1'b0);
        wait_prog(len);
        for (int i = 0; i < 16; i++) begin
            rd({7'h05, 4'(i)}, v, oe);
            chk("R4 partial page keeps others", v,
                (i == 3) ? 8'hC3 : (i == 9) ? 8'h19 : 8'h30 + 8'(i));
        end

        // R7 polling and R9 ignored load during busy.
        wr_byte(11'h123, 8'h4B, 1'b1);
        wait_busy();
        rd(11'h123, v, oe);
        chk("R7 poll bit7 inverted (0->1)", v, 8'hCB);
        wr_byte(11'h123, 8'hEE, 1'b1);
        while (prog_busy) tick(1);
        rd(11'h123, v, oe);
        chk("R7 true data after completion", v, 8'h4B);
        chk("R9 load during busy ignored", v, 8'h4B);
        tick(WIN + PROG);
        chk("R9 no further programming cycle", prog_busy, 0);
        wr_byte(11'h3F1, 8'hF0, 1'b0);
        wait_busy();
        rd(11'h3F1, v, oe);
        chk("R7 poll bit7 inverted (1->0)", v, 8'h70);
        while (prog_busy) tick(1);

        // R10: foreign-page load dropped, flag sticky until next page write.
        wr_byte(11'h210, 8'h11, 1'b1);
        wr_byte(11'h2A3, 8'h99, 1'b1);
        chk("R10 page_err set", page_err, 1);
        wait_prog(len);
        chk("R10 page_err sticky after commit", page_err, 1);
        rd(11'h2A3, v, oe);
        chk("R10 dropped byte unchanged", v, 8'h5C);
        rd(11'h210, v, oe);
        chk("R10 own-page byte written", v, 8'h11);
        wr_byte(11'h400, 8'h44, 1'b0);
        chk("R10 page_err cleared by new page", page_err, 0);
        wait_prog(len);
        rd(11'h400, v, oe);
        chk("R10 new page written", v, 8'h44);

        // R8: glitch of GL cycles rejected, GL+1 accepted.
        pulse(11'h000, 8'h3C, GL);
        tick(WIN + 20);
        chk("R8 glitch starts nothing", prog_busy, 0);
        rd(11'h000, v, oe);
        chk("R8 glitch leaves data", v, 8'hA5);
        pulse(11'h000, 8'h3C, GL + 1);
        wait_prog(len);
        rd(11'h000, v, oe);
        chk("R8 pulse above limit accepted", v, 8'h3C);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule